// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block sits behind the CPU write port of a programmable interrupt controller. Every write arrives as a one-cycle strobe that carries an address bit and a data byte. The block sorts each write into one of three kinds: a start word, a word with the address bit at 1, or any other write. From these it walks an initialization sequence that is two, three or four bytes long. The start word opens the sequence and always restarts it, whatever state the block is in. On a start word the block also clears the interrupt mask, puts the lowest priority on the highest-numbered request line and clears the special-mask flag. It sets the status-read selection to the request register and pulses a one-cycle re-arm signal to the edge-sense logic.

The start word holds two choices. The first says that the controller is alone in the system, so the cascade byte is skipped. The second says whether a mode byte follows. The second byte is always expected and holds the vector base. When the last expected byte has been taken in, the block reports that it is initialized. From then on, writes with the address bit at 1 load the interrupt mask.

The sequence lives in an enumerated state machine with five states:
- `ST_UNINIT`: after reset.
- `ST_WANT2`: waiting for the vector base.
- `ST_WANT3`: waiting for the cascade byte.
- `ST_WANT4`: waiting for the mode byte.
- `ST_READY`: initialized.

The transitions are named as follows:
- *start*: any state to `ST_WANT2`, on a start word.
- *base_to_casc*: `ST_WANT2` to `ST_WANT3` when single mode is off.
- *base_to_mode*: `ST_WANT2` to `ST_WANT4` when single mode is on and a mode byte is wanted.
- *base_to_ready*: `ST_WANT2` to `ST_READY` when single mode is on and no mode byte is wanted.
- *casc_to_mode*: `ST_WANT3` to `ST_WANT4` when a mode byte is wanted.
- *casc_to_ready*: `ST_WANT3` to `ST_READY` when no mode byte is wanted.
- *mode_to_ready*: `ST_WANT4` to `ST_READY`.
- *mask_load*: `ST_READY` to itself, on a write with the address bit at 1.

Any other write leaves the state unchanged.

Top module: `icw_sequencer`

## Requirements
- R1: After reset, the following hold: `init_done` is 0, `irq_mask` is 0, `low_prio_line` is 7 (all ones), `spec_mask_en` is 0, `rd_sel_isr` is 0, `edge_rearm` is 0, and all configuration fields are 0.
- R2: A strobed write with `wr_a0`=0 and `wr_data[4]`=1 is a start word. It restarts the sequence from any state, including part-way through a sequence and after initialization. `init_done` is 0 in the cycle after it.
- R3: In the cycle after a start word, `irq_mask` is 0, `low_prio_line` is 7, `spec_mask_en` is 0 and `rd_sel_isr` is 0 (request register). `edge_rearm` is 1 in exactly that cycle. The start word also stores `cfg_single`=`wr_data[1]` and `cfg_want4`=`wr_data[0]`, and clears `cfg_cascade` and `cfg_mode` to 0.
- R4: The first write with `wr_a0`=1 after a start word is stored in `cfg_vec_base`.
- R5: When `cfg_single` is 1, the cascade byte is skipped. Otherwise the next write with `wr_a0`=1 is stored in `cfg_cascade`. When `cfg_want4` is 1, one more write with `wr_a0`=1 is stored in `cfg_mode`. The sequence is therefore 2, 3 or 4 bytes long.
- R6: `init_done` rises in the cycle after the last expected byte is written. It stays 0 while bytes are still outstanding.
- R7: Once `init_done` is 1, a write with `wr_a0`=1 loads `irq_mask` from the byte written. Writes with `wr_a0`=1 during the sequence never touch `irq_mask`.
- R8: A write with `wr_a0`=0 and `wr_data[4]`=0 changes no output and no sequence state, in any state.
- R9: When `wr_stb` is 0, no output and no state changes, apart from `edge_rearm` returning to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_a0 | input | 1 | Address bit of the write |
| wr_data | input | 8 | Write data byte |
| cfg_single | output | 1 | Single-controller choice from the start word |
| cfg_want4 | output | 1 | Mode-byte-expected choice from the start word |
| cfg_vec_base | output | 8 | Vector base byte |
| cfg_cascade | output | 8 | Cascade byte |
| cfg_mode | output | 8 | Mode byte |
| irq_mask | output | 8 | Interrupt mask register |
| edge_rearm | output | 1 | One-cycle pulse that resets the edge-sense logic |
| low_prio_line | output | 3 | Index of the lowest-priority request line |
| spec_mask_en | output | 1 | Special mask mode flag |
| rd_sel_isr | output | 1 | Status-read selection: 0 = request register, 1 = in-service register |
| init_done | output | 1 | Initialization complete |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus and eight request lines. At that size every combination of the two choices in the start word can be swept, together with sixteen varied data patterns in the other start-word bits and in every byte of the sequence. Each sweep also places an ignored write and a mask write inside the sequence, and a second start word part-way through. This brings every state, every named transition and every reset side effect within reach of a port-level comparison.

// File: rtl/icw_pkg.sv
package icw_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_UNINIT = 3'd0,
        ST_WANT2  = 3'd1,
        ST_WANT3  = 3'd2,
        ST_WANT4  = 3'd3,
        ST_READY  = 3'd4
    } seq_st_t;

    // Classification of one write
    typedef enum logic [1:0] {
        WK_NONE  = 2'd0,
        WK_START = 2'd1,
        WK_ODD   = 2'd2,
        WK_OTHER = 2'd3
    } wr_kind_t;

    // Bit positions inside the start word
    localparam int START_MARK_BIT = 4;
    localparam int SINGLE_BIT     = 1;
    localparam int WANT4_BIT      = 0;

endpackage

// File: rtl/icw_wr_class.sv
module icw_wr_class
    import icw_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              wr_stb,
    input  logic              wr_a0,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_t          kind
);

    always_comb begin
        if (!wr_stb)
            kind = WK_NONE;
        else if (wr_a0)
            kind = WK_ODD;
        else if (wr_data[START_MARK_BIT])
            kind = WK_START;
        else
            kind = WK_OTHER;
    end

endmodule

// File: rtl/icw_seq_fsm.sv
module icw_seq_fsm
    import icw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wr_kind_t kind,
    input  logic     single_q,
    input  logic     want4_q,
    output logic     cap_start,
    output logic     cap_base,
    output logic     cap_casc,
    output logic     cap_mode,
    output logic     cap_mask,
    output logic     init_done
);

    seq_st_t st_q, st_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_UNINIT;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (kind == WK_START) begin
            st_d = ST_WANT2;                        // start
        end else if (kind == WK_ODD) begin
            unique case (st_q)
                ST_UNINIT: st_d = ST_UNINIT;
                ST_WANT2: begin
                    if (!single_q)    st_d = ST_WANT3;  // base_to_casc
                    else if (want4_q) st_d = ST_WANT4;  // base_to_mode
                    else              st_d = ST_READY;  // base_to_ready
                end
                ST_WANT3:  st_d = want4_q ? ST_WANT4 : ST_READY;
                ST_WANT4:  st_d = ST_READY;             // mode_to_ready
                ST_READY:  st_d = ST_READY;             // mask_load
                default:   st_d = ST_UNINIT;
            endcase
        end
    end

    // Capture strobes and status
    always_comb begin
        cap_start = (kind == WK_START);
        cap_base  = 1'b0;
        cap_casc  = 1'b0;
        cap_mode  = 1'b0;
        cap_mask  = 1'b0;
        if (kind == WK_ODD) begin
            unique case (st_q)
                ST_WANT2: cap_base = 1'b1;
                ST_WANT3: cap_casc = 1'b1;
                ST_WANT4: cap_mode = 1'b1;
                ST_READY: cap_mask = 1'b1;
                default:  ;
            endcase
        end
    end

    assign init_done = (st_q == ST_READY);

    // R9
    idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_NONE) |=> $stable(st_q));

    // R8
    other_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_OTHER) |=> $stable(st_q));

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WK_START) |=> (st_q == ST_WANT2));

    // R6
    done_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(kind == WK_ODD));

    // R5
    single_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WANT2 && kind == WK_ODD && single_q) |=> (st_q != ST_WANT3));

endmodule

// File: rtl/icw_cfg_regs.sv
module icw_cfg_regs
    import icw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int PRIO_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cap_start,
    input  logic              cap_base,
    input  logic              cap_casc,
    input  logic              cap_mode,
    input  logic              cap_mask,
    output logic              single_q,
    output logic              want4_q,
    output logic [DATA_W-1:0] vec_base_q,
    output logic [DATA_W-1:0] cascade_q,
    output logic [DATA_W-1:0] mode_q,
    output logic [LINES-1:0]  mask_q,
    output logic              rearm_q,
    output logic [PRIO_W-1:0] low_prio_q,
    output logic              smm_q,
    output logic              rd_isr_q
);

    localparam logic [PRIO_W-1:0] LOWEST = PRIO_W'(LINES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            single_q   <= 1'b0;
            want4_q    <= 1'b0;
            vec_base_q <= '0;
            cascade_q  <= '0;
            mode_q     <= '0;
            mask_q     <= '0;
            rearm_q    <= 1'b0;
            low_prio_q <= LOWEST;
            smm_q      <= 1'b0;
            rd_isr_q   <= 1'b0;
        end else begin
            rearm_q <= cap_start;
            if (cap_start) begin
                single_q   <= wr_data[SINGLE_BIT];
                want4_q    <= wr_data[WANT4_BIT];
                cascade_q  <= '0;
                mode_q     <= '0;
                mask_q     <= '0;
                low_prio_q <= LOWEST;
                smm_q      <= 1'b0;
                rd_isr_q   <= 1'b0;
            end
            if (cap_base) vec_base_q <= wr_data;
            if (cap_casc) cascade_q  <= wr_data;
            if (cap_mode) mode_q     <= wr_data;
            if (cap_mask) mask_q     <= wr_data[LINES-1:0];
        end
    end

    // R3
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start |=> (mask_q == '0 && low_prio_q == LOWEST && !smm_q && !rd_isr_q && rearm_q));

    // R3
    rearm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_start |=> !rearm_q);

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_mask && !cap_start) |=> $stable(mask_q));

endmodule

// File: rtl/icw_sequencer.sv
module icw_sequencer
    import icw_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINES  = 8,
    localparam int PRIO_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              wr_a0,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cfg_single,
    output logic              cfg_want4,
    output logic [DATA_W-1:0] cfg_vec_base,
    output logic [DATA_W-1:0] cfg_cascade,
    output logic [DATA_W-1:0] cfg_mode,
    output logic [LINES-1:0]  irq_mask,
    output logic              edge_rearm,
    output logic [PRIO_W-1:0] low_prio_line,
    output logic              spec_mask_en,
    output logic              rd_sel_isr,
    output logic              init_done
);

    wr_kind_t kind;
    logic cap_start, cap_base, cap_casc, cap_mode, cap_mask;

    icw_wr_class #(.DATA_W(DATA_W)) u_class (
        .wr_stb  (wr_stb),
        .wr_a0   (wr_a0),
        .wr_data (wr_data),
        .kind    (kind)
    );

    icw_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .single_q  (cfg_single),
        .want4_q   (cfg_want4),
        .cap_start (cap_start),
        .cap_base  (cap_base),
        .cap_casc  (cap_casc),
        .cap_mode  (cap_mode),
        .cap_mask  (cap_mask),
        .init_done (init_done)
    );

    icw_cfg_regs #(.DATA_W(DATA_W), .LINES(LINES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data    (wr_data),
        .cap_start  (cap_start),
        .cap_base   (cap_base),
        .cap_casc   (cap_casc),
        .cap_mode   (cap_mode),
        .cap_mask   (cap_mask),
        .single_q   (cfg_single),
        .want4_q    (cfg_want4),
        .vec_base_q (cfg_vec_base),
        .cascade_q  (cfg_cascade),
        .mode_q     (cfg_mode),
        .mask_q     (irq_mask),
        .rearm_q    (edge_rearm),
        .low_prio_q (low_prio_line),
        .smm_q      (spec_mask_en),
        .rd_isr_q   (rd_sel_isr)
    );

    // R6
    done_blocks_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && wr_stb && wr_a0) |=> init_done);

endmodule

// File: tb/icw_sequencer_tb_top.sv
module icw_sequencer_tb_top;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_a0 = 1'b0;
    logic [7:0] wr_data = 8'h00;

    logic       cfg_single, cfg_want4, edge_rearm, spec_mask_en, rd_sel_isr, init_done;
    logic [7:0] cfg_vec_base, cfg_cascade, cfg_mode, irq_mask;
    logic [2:0] low_prio_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    icw_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_a0(wr_a0), .wr_data(wr_data),
        .cfg_single(cfg_single), .cfg_want4(cfg_want4), .cfg_vec_base(cfg_vec_base),
        .cfg_cascade(cfg_cascade), .cfg_mode(cfg_mode), .irq_mask(irq_mask),
        .edge_rearm(edge_rearm), .low_prio_line(low_prio_line), .spec_mask_en(spec_mask_en),
        .rd_sel_isr(rd_sel_isr), .init_done(init_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one strobed write; returns at the negedge after it was clocked in
    task automatic wr(input logic a0, input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_a0 = a0; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0; wr_a0 = 1'b0; wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] w1, b2, b3, b4, mk, exp_casc, exp_mode;
        logic sgl, w4;
        idle(3);
        // R1 reset values
        chk("R1", "init_done", init_done, 0);
        chk("R1", "irq_mask", irq_mask, 0);
        chk("R1", "low_prio", low_prio_line, 7);
        chk("R1", "smm", spec_mask_en, 0);
        chk("R1", "rd_sel", rd_sel_isr, 0);
        chk("R1", "edge_rearm", edge_rearm, 0);
        chk("R1", "vec_base", cfg_vec_base, 0);
        rst_n = 1'b1;
        idle(2);
        // R7 odd write before init does nothing to the mask
        wr(1'b1, 8'hA5);
        chk("R7", "mask before init", irq_mask, 0);
        chk("R6", "done before init", init_done, 0);

        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 16; v++) begin
                sgl = m[1]; w4 = m[0];
                w1 = {v[3:1], 1'b1, v[0], v[2], sgl, w4};
                b2 = 8'(v * 17 + m * 5 + 3);
                b3 = 8'(v * 29 + 1) ^ 8'h5A;
                b4 = 8'(v * 7 + m) ^ 8'hC3;
                mk = 8'(v * 13 + m * 3 + 1);

                // Start word, with a nonzero mask loaded before
                wr(1'b0, w1);
                chk("R3", "edge_rearm pulse", edge_rearm, 1);
                chk("R3", "mask cleared", irq_mask, 0);
                chk("R3", "low_prio", low_prio_line, 7);
                chk("R3", "smm", spec_mask_en, 0);
                chk("R3", "rd_sel", rd_sel_isr, 0);
                chk("R3", "single", cfg_single, sgl);
                chk("R3", "want4", cfg_want4, w4);
                chk("R2", "done after start", init_done, 0);
                idle(1);
                chk("R3", "edge_rearm one cycle", edge_rearm, 0);

                // Ignored write inside the sequence
                wr(1'b0, w1 & 8'hEF);
                chk("R8", "done hold", init_done, 0);
                chk("R8", "single hold", cfg_single, sgl);
                chk("R8", "rearm stays low", edge_rearm, 0);

                if (v == 5) begin
                    // R2 restart part-way through
                    wr(1'b1, 8'hEE);
                    wr(1'b0, w1);
                    chk("R2", "restart done low", init_done, 0);
                    chk("R2", "restart rearm", edge_rearm, 1);
                end

                wr(1'b1, b2);
                chk("R4", "vec_base", cfg_vec_base, b2);
                chk("R7", "mask untouched in seq", irq_mask, 0);
                exp_casc = 8'h00; exp_mode = 8'h00;
                if (!sgl) begin
                    chk("R6", "done after b2", init_done, 0);
                    wr(1'b1, b3);
                    exp_casc = b3;
                end
                if (w4) begin
                    chk("R6", "done before b4", init_done, 0);
                    wr(1'b1, b4);
                    exp_mode = b4;
                end
                chk("R6", "done after last", init_done, 1);
                chk("R5", "cascade", cfg_cascade, exp_casc);
                chk("R5", "mode", cfg_mode, exp_mode);
                chk("R4", "vec_base kept", cfg_vec_base, b2);
                idle(2);
                chk("R9", "idle done", init_done, 1);
                chk("R9", "idle cascade", cfg_cascade, exp_casc);

                // Mask load after init
                wr(1'b1, mk);
                chk("R7", "mask load", irq_mask, mk);
                chk("R7", "vec_base unchanged", cfg_vec_base, b2);
                chk("R7", "mode unchanged", cfg_mode, exp_mode);
                wr(1'b0, 8'h0B);
                chk("R8", "mask hold", irq_mask, mk);
                chk("R8", "done hold ready", init_done, 1);
                chk("R8", "cascade hold", cfg_cascade, exp_casc);
            end
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule